// File: doc/BRIEF.md
# Retriggerable Resettable Pulse Generator

This block is a clock-synchronous monostable. It watches two asynchronous trigger pins, one that fires on a falling edge and one that fires on a rising edge, and each gates the other. A qualified trigger starts a pulse that lasts a programmable number of clock cycles. The pulse appears on a pair of complementary outputs.

A trigger that arrives while the pulse is running reloads the full length from that point, so a steady train of triggers can hold the output active for as long as it lasts. Two exceptions apply. First, a trigger that lands inside a short recovery window just after an accepted trigger is dropped. Second, when the lockout input is high, any trigger that arrives during the pulse is dropped.

An active-low level clear overrides everything. It cuts the pulse off within the current cycle and holds off new pulses for as long as it stays low. Both trigger pins pass through a two-stage synchroniser, so each level must be held for at least two clock cycles.

Top module: `retrig_pulse_gen`

## Requirements
- R1: A falling edge on `trig_fall_n` while `trig_rise` is low and `clear_n` is high is a trigger. `pulse_q` goes high on the third rising clock edge after the pin changes.
- R2: A rising edge on `trig_rise` while `trig_fall_n` is high and `clear_n` is high is a trigger, with the same three-edge latency as R1.
- R3: A falling edge on `trig_fall_n` while `trig_rise` is high produces no pulse. A rising edge on `trig_rise` while `trig_fall_n` is low also produces no pulse.
- R4: `width` is sampled on the clock edge that starts the pulse, and `pulse_q` then stays high for exactly that many cycles. Changing `width` later has no effect on the running pulse. A trigger with `width` equal to 0 produces no pulse.
- R5: An accepted trigger during a pulse reloads the full width. If the second trigger change comes G cycles after the first, `pulse_q` is high for G + `width` cycles in total.
- R6: A trigger presented on any of the RECOVER (default 4) clock edges that follow an accepted trigger is ignored. With default settings, a retrigger G = 4 cycles after the first has no effect, while G = 5 extends the pulse.
- R7: While `lockout` is high, triggers that arrive while `pulse_q` is high are ignored, and the pulse ends at its original length.
- R8: While `clear_n` is low, `pulse_q` is low in the same cycle and no trigger starts a pulse. After `clear_n` returns high, no pulse starts from triggers that arrived while it was low.
- R9: `pulse_qn` is always the inverse of `pulse_q`.
- R10: While `rst` is high, and after it is released with no trigger, `pulse_q` is 0 and `pulse_qn` is 1. Reset also clears the timer and the recovery window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_fall_n | input | 1 | Asynchronous trigger pin, fires on its falling edge |
| trig_rise | input | 1 | Asynchronous trigger pin, fires on its rising edge |
| clear_n | input | 1 | Active-low level clear, overrides all |
| lockout | input | 1 | High: no retrigger while the pulse runs |
| width | input | WIDTH_W | Pulse length in clock cycles, sampled at load |
| pulse_q | output | 1 | Pulse output, active high |
| pulse_qn | output | 1 | Complement of pulse_q |

## Verification
The pulse is due on the third rising edge after a trigger pin changes. The bench drives inputs 1 ns after an edge and samples at that same point, so it checks that the output is still low after the second edge and high after the third. The pulse length is measured by counting, one sample per cycle, the cycles in which `pulse_q` is high, so any extension from a retrigger or cut from the recovery window shows up as a difference in that count. A clear must act within the cycle it is applied, so the bench samples the outputs 1 ns after driving `clear_n` low, before the next edge.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

    // Trigger pins as one bundle: fall_n fires on 1->0, rise fires on 0->1.
    typedef struct packed {
        logic fall_n;
        logic rise;
    } trig_pins_t;

    // Levels the pins rest at when no trigger is intended.
    localparam trig_pins_t PINS_IDLE = '{fall_n: 1'b1, rise: 1'b0};

    // Which pin produced a qualified event in the current cycle.
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_FALL = 2'd1,
        EV_RISE = 2'd2
    } trig_ev_t;

    typedef enum logic {
        TM_IDLE = 1'b0,
        TM_RUN  = 1'b1
    } tmr_state_t;

    function automatic logic went_low(input logic was, input logic is_now);
        return was & ~is_now;
    endfunction

    function automatic logic went_high(input logic was, input logic is_now);
        return ~was & is_now;
    endfunction

endpackage

// File: rtl/rpg_sync.sv
module rpg_sync #(
    parameter int            W       = 2,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_r [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_r[i] <= RST_VAL;
        end else begin
            stage_r[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_r[i] <= stage_r[i-1];
        end
    end

    assign dout = stage_r[STAGES-1];
endmodule

// File: rtl/rpg_edge_gate.sv
module rpg_edge_gate
    import rpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear_n,
    input  trig_pins_t pins,
    output trig_ev_t   ev
);
    trig_pins_t prev_r;

    always_ff @(posedge clk) begin
        if (rst) prev_r <= PINS_IDLE;
        else     prev_r <= pins;
    end

    // Each edge is qualified by the level of the other pin.
    always_comb begin
        ev = EV_NONE;
        if (clear_n) begin
            if (went_low(prev_r.fall_n, pins.fall_n) && !pins.rise)
                ev = EV_FALL;
            else if (went_high(prev_r.rise, pins.rise) && pins.fall_n)
                ev = EV_RISE;
        end
    end

    // R3: a pin cannot produce the same edge on two consecutive cycles
    p_no_double_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_FALL) |=> (ev != EV_FALL));
    p_no_double_rise_r3: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_RISE) |=> (ev != EV_RISE));
endmodule

// File: rtl/rpg_timer.sv
module rpg_timer
    import rpg_pkg::*;
#(
    parameter int WIDTH_W = 8,
    parameter int RECOVER = 4,
    parameter int REC_W   = $clog2(RECOVER + 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear_n,
    input  logic               lockout,
    input  logic [WIDTH_W-1:0] width,
    input  trig_ev_t           ev,
    output logic               q
);
    localparam logic [WIDTH_W-1:0] ONE_W   = WIDTH_W'(1);
    localparam logic [REC_W-1:0]   ONE_R   = REC_W'(1);
    localparam logic [REC_W-1:0]   REC_LD  = REC_W'(RECOVER);

    tmr_state_t         st_r;
    logic [WIDTH_W-1:0] cnt_r;
    logic [REC_W-1:0]   rec_r;
    logic               blind;
    logic               locked;
    logic               accept;

    assign blind  = (rec_r != '0);
    assign locked = lockout && (st_r == TM_RUN);
    assign accept = (ev != EV_NONE) && clear_n && (width != '0) && !blind && !locked;

    always_ff @(posedge clk) begin
        if (rst || !clear_n) begin
            st_r  <= TM_IDLE;
            cnt_r <= '0;
            rec_r <= '0;
        end else if (accept) begin
            st_r  <= TM_RUN;
            cnt_r <= width;
            rec_r <= REC_LD;
        end else begin
            if (blind) rec_r <= rec_r - ONE_R;
            if (st_r == TM_RUN) begin
                if (cnt_r == ONE_W) begin
                    st_r  <= TM_IDLE;
                    cnt_r <= '0;
                end else begin
                    cnt_r <= cnt_r - ONE_W;
                end
            end
        end
    end

    assign q = (st_r == TM_RUN);

    // R1: the pulse only starts after a qualified event from the edge logic
    p_start_needs_event_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(q) |-> $past(ev != EV_NONE));
    // R4: a running pulse always has cycles left; width 0 never starts one
    p_run_has_count_r4: assert property (@(posedge clk) disable iff (rst)
        (st_r == TM_RUN) |-> (cnt_r != '0));
    p_zero_width_r4: assert property (@(posedge clk) disable iff (rst)
        (st_r == TM_IDLE && width == '0) |=> (st_r == TM_IDLE));
    // R6: inside the recovery window the count only runs down
    p_blind_window_r6: assert property (@(posedge clk) disable iff (rst)
        (blind && st_r == TM_RUN && cnt_r > ONE_W && clear_n)
        |=> (cnt_r == $past(cnt_r) - ONE_W));
    // R7: with lockout during a pulse the count only runs down
    p_lockout_r7: assert property (@(posedge clk) disable iff (rst)
        (lockout && st_r == TM_RUN && cnt_r > ONE_W && clear_n)
        |=> (cnt_r == $past(cnt_r) - ONE_W));
    // R8: a clear leaves the timer idle
    p_clear_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !clear_n |=> (st_r == TM_IDLE && rec_r == '0));
endmodule

// File: rtl/retrig_pulse_gen.sv
module retrig_pulse_gen
    import rpg_pkg::*;
#(
    parameter int WIDTH_W     = 8,
    parameter int RECOVER     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trig_fall_n,
    input  logic               trig_rise,
    input  logic               clear_n,
    input  logic               lockout,
    input  logic [WIDTH_W-1:0] width,
    output logic               pulse_q,
    output logic               pulse_qn
);
    localparam int PIN_W = $bits(trig_pins_t);

    trig_pins_t raw_pins;
    logic [PIN_W-1:0] synced_bits;
    trig_pins_t synced_pins;
    trig_ev_t   ev;
    logic       tmr_q;

    assign raw_pins = '{fall_n: trig_fall_n, rise: trig_rise};

    rpg_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_pins),
        .dout (synced_bits)
    );

    assign synced_pins = trig_pins_t'(synced_bits);

    rpg_edge_gate gate_i (
        .clk     (clk),
        .rst     (rst),
        .clear_n (clear_n),
        .pins    (synced_pins),
        .ev      (ev)
    );

    rpg_timer #(
        .WIDTH_W (WIDTH_W),
        .RECOVER (RECOVER)
    ) timer_i (
        .clk     (clk),
        .rst     (rst),
        .clear_n (clear_n),
        .lockout (lockout),
        .width   (width),
        .ev      (ev),
        .q       (tmr_q)
    );

    // The clear masks the registered pulse at once; the timer drops it next edge.
    assign pulse_q  = tmr_q & clear_n;
    assign pulse_qn = ~pulse_q;

    // R10: no pulse directly after reset
    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> !pulse_q);
endmodule

// File: tb/retrig_pulse_gen_tb_top.sv
`timescale 1ns/100ps
module retrig_pulse_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       a_in = 1'b1;
    logic       b_in = 1'b0;
    logic       clear_n = 1'b1;
    logic       lockout = 1'b0;
    logic [7:0] width = 8'd0;
    logic       pulse_q;
    logic       pulse_qn;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    retrig_pulse_gen dut_i (
        .clk         (clk),
        .rst         (rst),
        .trig_fall_n (a_in),
        .trig_rise   (b_in),
        .clear_n     (clear_n),
        .lockout     (lockout),
        .width       (width),
        .pulse_q     (pulse_q),
        .pulse_qn    (pulse_qn)
    );

    // fields: kind[18:17] width[16:9] lock[8] expected_len[7:0]
    // kind 0: A falls, B low; 1: B rises, A high; 2: A falls, B high; 3: B rises, A low
    localparam int NV = 8;
    localparam logic [18:0] VEC [NV] = '{
        {2'd0, 8'd5,   1'b0, 8'd5},
        {2'd1, 8'd1,   1'b0, 8'd1},
        {2'd0, 8'd0,   1'b0, 8'd0},
        {2'd1, 8'd12,  1'b1, 8'd12},
        {2'd2, 8'd5,   1'b0, 8'd0},
        {2'd3, 8'd5,   1'b0, 8'd0},
        {2'd0, 8'd255, 1'b0, 8'd255},
        {2'd1, 8'd2,   1'b0, 8'd2}
    };

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // Called right after the trigger pin is driven.
    task automatic run_pulse(input string req, input int exp_len);
        int len = 0;
        step();
        step();
        chk(req, int'(pulse_q), 0);
        step();
        chk(req, int'(pulse_q), (exp_len > 0) ? 1 : 0);
        for (int i = 0; i < 400; i++) begin
            if (!pulse_q) break;
            if (i == 0) chk("R9", int'(pulse_qn), 0);
            len++;
            step();
        end
        chk(req, len, exp_len);
        chk("R9", int'(pulse_qn), int'(!pulse_q));
    endtask

    // A falls at cycle 0 and again at cycle gap; highs counted over a window.
    task automatic train(input string req, input int gap, input logic lk,
                         input int wid, input int exp_hi);
        int hi = 0;
        width   = wid[7:0];
        lockout = lk;
        for (int i = 0; i < 60; i++) begin
            if (i > 0) hi += int'(pulse_q);
            if (i == 0 || i == gap) a_in = 1'b0;
            if (i == 2 || i == gap + 2) a_in = 1'b1;
            step();
        end
        chk(req, hi, exp_hi);
        lockout = 1'b0;
        idle(6);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R10: reset state
        idle(3);
        chk("R10", int'(pulse_q), 0);
        chk("R10", int'(pulse_qn), 1);
        rst = 1'b0;
        idle(4);
        chk("R10", int'(pulse_q), 0);

        // Vector walk: R1 R2 R3 R4
        for (int v = 0; v < NV; v++) begin
            logic [1:0] kd;
            string      tag;
            kd  = VEC[v][18:17];
            tag = (kd == 2'd0) ? "R1" : (kd == 2'd1) ? "R2" : "R3";
            if (VEC[v][16:9] == 8'd0) tag = "R4";
            width = 8'd0;
            if (kd == 2'd2) b_in = 1'b1;
            if (kd == 2'd3) a_in = 1'b0;
            idle(8);
            width   = VEC[v][16:9];
            lockout = VEC[v][8];
            if (kd == 2'd0 || kd == 2'd2) a_in = 1'b0;
            else                          b_in = 1'b1;
            run_pulse(tag, int'(VEC[v][7:0]));
            width   = 8'd0;
            lockout = 1'b0;
            a_in    = 1'b1;
            b_in    = 1'b0;
            idle(8);
        end

        // R4: width changed during the pulse has no effect
        width = 8'd6;
        a_in  = 1'b0;
        begin
            int len = 0;
            step(); step(); step();
            width = 8'd30;
            for (int i = 0; i < 100; i++) begin
                if (!pulse_q) break;
                len++;
                step();
            end
            chk("R4", len, 6);
        end
        a_in = 1'b1;
        idle(8);

        // R5: retrigger 6 cycles after the first reloads the width
        train("R5", 6, 1'b0, 10, 16);
        // R6: retrigger inside the recovery window is ignored, just after it counts
        train("R6", 4, 1'b0, 10, 10);
        train("R6", 5, 1'b0, 10, 15);
        // R7: lockout drops the retrigger
        train("R7", 6, 1'b1, 10, 10);

        // R8: clear cuts a pulse at once and blocks triggers
        width = 8'd20;
        a_in  = 1'b0;
        idle(8);
        chk("R8", int'(pulse_q), 1);
        clear_n = 1'b0;
        #1;
        chk("R8", int'(pulse_q), 0);
        chk("R9", int'(pulse_qn), 1);
        a_in = 1'b1;
        idle(3);
        a_in = 1'b0;
        begin
            int hi = 0;
            for (int i = 0; i < 8; i++) begin
                step();
                hi += int'(pulse_q);
            end
            clear_n = 1'b1;
            for (int i = 0; i < 10; i++) begin
                step();
                hi += int'(pulse_q);
            end
            chk("R8", hi, 0);
        end
        a_in = 1'b1;
        idle(6);
        width = 8'd3;
        b_in  = 1'b1;
        run_pulse("R8", 3);
        b_in = 1'b0;
        idle(6);

        // R10: reset in the middle of a pulse
        width = 8'd40;
        a_in  = 1'b0;
        idle(6);
        chk("R10", int'(pulse_q), 1);
        rst = 1'b1;
        step();
        chk("R10", int'(pulse_q), 0);
        chk("R10", int'(pulse_qn), 1);
        a_in = 1'b1;
        rst  = 1'b0;
        idle(10);
        chk("R10", int'(pulse_q), 0);

        summary();
        $finish;
    end
endmodule